// File: doc/BRIEF.md
# Call, Return and Interrupt Stack Sequencer

This block performs the stack side of control transfer for a segmented 16-bit processor: near and far subroutine calls, near and far returns, software interrupts with a type byte, interrupt-on-overflow, and interrupt return. It holds the stack pointer, instruction pointer and code segment registers. It reads the live flags word from a separate flag unit. It reaches memory through one word-wide port with a request/acknowledge handshake. The stack pointer is used directly as the memory address; stack segment arithmetic, instruction fetch and decode are handled elsewhere.

A caller pulses `start_i` together with an operation code, a target offset and segment, an interrupt type byte and the overflow flag. The sequencer then issues its pushes, pops and vector reads one at a time, and each access waits for its acknowledge. A one-cycle `done_o` pulse marks the end of the sequence. On interrupt entry it also asks the flag unit to clear the interrupt-enable flag. On interrupt return it hands the popped flags word back to the flag unit.

The states are ST_IDLE, ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP, ST_VEC_IP, ST_VEC_CS, ST_POP_IP, ST_POP_CS, ST_POP_FL and ST_DONE.

From ST_IDLE, an accepted start leads to the first step of the chosen operation:
- near call → ST_PUSH_IP
- far call → ST_PUSH_CS
- any return or IRET → ST_POP_IP
- software interrupt, or INTO with OF set → ST_PUSH_FL
- INTO with OF clear, or the spare code → ST_DONE

Every memory state advances only on acknowledge:
- ST_PUSH_FL → ST_PUSH_CS → ST_PUSH_IP
- ST_PUSH_IP → ST_VEC_IP for interrupts, otherwise → ST_DONE
- ST_VEC_IP → ST_VEC_CS → ST_DONE
- ST_POP_IP → ST_DONE for a near return, otherwise → ST_POP_CS
- ST_POP_CS → ST_POP_FL for IRET, otherwise → ST_DONE
- ST_POP_FL → ST_DONE

ST_DONE always returns to ST_IDLE after one cycle.

Top module: `ctlflow_seq`

## Requirements
- R1: After reset, the SP, IP and CS outputs equal the parameters RST_SP, RST_IP and RST_CS. No memory request, done pulse or busy indication is present.
- R2: The operation codes are: 0 near call, 1 far call, 2 near return, 3 far return, 4 software interrupt, 5 interrupt-on-overflow, 6 interrupt return, 7 no operation. A near call writes the current IP to SP-2, leaves SP lowered by 2, and ends with IP equal to the target offset.
- R3: A far call writes the current CS to SP-2 and then the current IP to SP-4. It leaves SP lowered by 4 and ends with CS and IP equal to the target segment and offset. Every write goes to the address SP-2 as seen during that write.
- R4: A near return reads IP from address SP and raises SP by 2.
- R5: A far return reads IP from address SP and then CS from SP+2, raising SP by 4 in total.
- R6: A software interrupt writes flags to SP-2, CS to SP-4 and IP to SP-6, then reads the new IP from type×4 and the new CS from type×4+2, over the full type range 0x00 to 0xFF. `clr_if_o` pulses together with `done_o`.
- R7: Interrupt-on-overflow with OF set behaves as a software interrupt of type 4: vectors at 0x0010 and 0x0012, the same three writes, and a `clr_if_o` pulse.
- R8: Interrupt-on-overflow with OF clear, and operation code 7, make no memory request and leave SP, IP and CS unchanged. They raise `done_o` in the cycle after the start, without `clr_if_o`.
- R9: Interrupt return reads IP from SP, CS from SP+2 and the flags word from SP+4, and raises SP by 6. `flags_load_o` pulses with `done_o` while `flags_o` carries the popped word.
- R10: A request holds its address and direction until acknowledged. SP, IP and CS change only in a cycle that follows an acknowledge.
- R11: `done_o` is a single-cycle pulse in the cycle after the final acknowledge. `busy_o` is high from the cycle after an accepted start through the done cycle.
- R12: A start pulse while the block is busy is ignored: the ongoing sequence's accesses and final registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_i | input | 3 | Operation code |
| tgt_off_i | input | W | Target offset for calls |
| tgt_seg_i | input | W | Target segment for far calls |
| int_type_i | input | TYPE_W | Software interrupt type |
| of_i | input | 1 | Overflow flag for interrupt-on-overflow |
| flags_i | input | W | Current flags word to push |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write enable of the request |
| mem_addr_o | output | W | Word address |
| mem_wdata_o | output | W | Write data |
| mem_rdata_i | input | W | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | End-of-sequence pulse |
| clr_if_o | output | 1 | Clear interrupt-enable request to flag unit |
| flags_load_o | output | 1 | Popped flags are valid on flags_o |
| flags_o | output | W | Flags word popped by interrupt return |
| sp_o | output | W | Stack pointer |
| ip_o | output | W | Instruction pointer |
| cs_o | output | W | Code segment |

## Verification
Each operation is driven under acknowledge latencies of zero, one and two wait cycles. This separates sequencing that depends on ack timing from sequencing that only works when ack arrives at once.

Calls are paired with matching returns, so the popped values must equal what the block itself wrote. Interrupt entries use types 3 and 0xFF and the overflow case, which distinguishes vector arithmetic from a fixed table address; the overflow-clear and spare codes show the no-traffic path. A second start injected in the middle of a far call tells apart an FSM that restarts on start from one that locks it out.

// File: rtl/ctlflow_pkg.sv
package ctlflow_pkg;

    typedef enum logic [2:0] {
        OP_NCALL = 3'd0,
        OP_FCALL = 3'd1,
        OP_NRET  = 3'd2,
        OP_FRET  = 3'd3,
        OP_SWINT = 3'd4,
        OP_OVINT = 3'd5,
        OP_IRET  = 3'd6,
        OP_NONE  = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_VEC_IP,
        ST_VEC_CS,
        ST_POP_IP,
        ST_POP_CS,
        ST_POP_FL,
        ST_DONE
    } st_e;

    localparam logic [7:0] OVF_VECTOR_TYPE = 8'd4;

endpackage

// File: rtl/ctlflow_ctrl.sv
module ctlflow_ctrl
    import ctlflow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  op_e  op_i,
    input  logic of_i,
    input  logic ack_i,
    output st_e  state_o,
    output op_e  op_q_o,
    output logic take_o,
    output logic req_o,
    output logic we_o,
    output logic busy_o,
    output logic done_o,
    output logic clr_if_o,
    output logic flags_load_o
);

    st_e  state_q, state_d;
    op_e  op_q;
    logic ovf_q;

    assign take_o = (state_q == ST_IDLE) && start_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_o) begin
                op_q  <= op_i;
                ovf_q <= of_i;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    unique case (op_i)
                        OP_NCALL: state_d = ST_PUSH_IP;
                        OP_FCALL: state_d = ST_PUSH_CS;
                        OP_NRET,
                        OP_FRET,
                        OP_IRET:  state_d = ST_POP_IP;
                        OP_SWINT: state_d = ST_PUSH_FL;
                        OP_OVINT: state_d = of_i ? ST_PUSH_FL : ST_DONE;
                        OP_NONE:  state_d = ST_DONE;
                    endcase
                end
            end
            ST_PUSH_FL: if (ack_i) state_d = ST_PUSH_CS;
            ST_PUSH_CS: if (ack_i) state_d = ST_PUSH_IP;
            ST_PUSH_IP: if (ack_i) state_d = (op_q == OP_SWINT || op_q == OP_OVINT) ? ST_VEC_IP : ST_DONE;
            ST_VEC_IP:  if (ack_i) state_d = ST_VEC_CS;
            ST_VEC_CS:  if (ack_i) state_d = ST_DONE;
            ST_POP_IP:  if (ack_i) state_d = (op_q == OP_NRET) ? ST_DONE : ST_POP_CS;
            ST_POP_CS:  if (ack_i) state_d = (op_q == OP_IRET) ? ST_POP_FL : ST_DONE;
            ST_POP_FL:  if (ack_i) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        req_o        = (state_q inside {ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP, ST_VEC_IP,
                                        ST_VEC_CS, ST_POP_IP, ST_POP_CS, ST_POP_FL});
        we_o         = (state_q inside {ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP});
        done_o       = (state_q == ST_DONE);
        clr_if_o     = done_o && ((op_q == OP_SWINT) || (op_q == OP_OVINT && ovf_q));
        flags_load_o = done_o && (op_q == OP_IRET);
    end

    assign state_o = state_q;
    assign op_q_o  = op_q;

endmodule

// File: rtl/ctlflow_dpath.sv
module ctlflow_dpath
    import ctlflow_pkg::*;
#(
    parameter int             W      = 16,
    parameter int             TYPE_W = 8,
    parameter logic [W-1:0]   RST_SP = 16'h0200,
    parameter logic [W-1:0]   RST_IP = 16'h0100,
    parameter logic [W-1:0]   RST_CS = 16'hF000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  st_e               state_i,
    input  op_e               op_q_i,
    input  op_e               op_i,
    input  logic              take_i,
    input  logic              ack_i,
    input  logic [W-1:0]      tgt_off_i,
    input  logic [W-1:0]      tgt_seg_i,
    input  logic [TYPE_W-1:0] int_type_i,
    input  logic [W-1:0]      flags_i,
    input  logic [W-1:0]      rdata_i,
    output logic [W-1:0]      addr_o,
    output logic [W-1:0]      wdata_o,
    output logic [W-1:0]      sp_o,
    output logic [W-1:0]      ip_o,
    output logic [W-1:0]      cs_o,
    output logic [W-1:0]      flags_o
);

    localparam int           PAD  = W - TYPE_W - 2;
    localparam logic [W-1:0] STEP = 2;

    logic [W-1:0]      sp_q, ip_q, cs_q, fl_q, off_q, seg_q;
    logic [TYPE_W-1:0] vtype_q;
    logic [W-1:0]      vec_base;

    assign vec_base = {{PAD{1'b0}}, vtype_q, 2'b00};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q    <= RST_SP;
            ip_q    <= RST_IP;
            cs_q    <= RST_CS;
            fl_q    <= '0;
            off_q   <= '0;
            seg_q   <= '0;
            vtype_q <= '0;
        end else begin
            if (take_i) begin
                off_q   <= tgt_off_i;
                seg_q   <= tgt_seg_i;
                vtype_q <= (op_i == OP_OVINT) ? TYPE_W'(OVF_VECTOR_TYPE) : int_type_i;
            end
            if (ack_i) begin
                unique case (state_i)
                    ST_PUSH_FL, ST_PUSH_CS: sp_q <= sp_q - STEP;
                    ST_PUSH_IP: begin
                        sp_q <= sp_q - STEP;
                        if (op_q_i == OP_NCALL || op_q_i == OP_FCALL) ip_q <= off_q;
                        if (op_q_i == OP_FCALL) cs_q <= seg_q;
                    end
                    ST_VEC_IP: ip_q <= rdata_i;
                    ST_VEC_CS: cs_q <= rdata_i;
                    ST_POP_IP: begin ip_q <= rdata_i; sp_q <= sp_q + STEP; end
                    ST_POP_CS: begin cs_q <= rdata_i; sp_q <= sp_q + STEP; end
                    ST_POP_FL: begin fl_q <= rdata_i; sp_q <= sp_q + STEP; end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        addr_o  = '0;
        wdata_o = '0;
        unique case (state_i)
            ST_PUSH_FL: begin addr_o = sp_q - STEP; wdata_o = flags_i; end
            ST_PUSH_CS: begin addr_o = sp_q - STEP; wdata_o = cs_q;    end
            ST_PUSH_IP: begin addr_o = sp_q - STEP; wdata_o = ip_q;    end
            ST_VEC_IP:  addr_o = vec_base;
            ST_VEC_CS:  addr_o = vec_base + STEP;
            ST_POP_IP, ST_POP_CS, ST_POP_FL: addr_o = sp_q;
            default: ;
        endcase
    end

    assign sp_o    = sp_q;
    assign ip_o    = ip_q;
    assign cs_o    = cs_q;
    assign flags_o = fl_q;

endmodule

// File: rtl/ctlflow_seq.sv
module ctlflow_seq
    import ctlflow_pkg::*;
#(
    parameter int           W      = 16,
    parameter int           TYPE_W = 8,
    parameter logic [W-1:0] RST_SP = 16'h0200,
    parameter logic [W-1:0] RST_IP = 16'h0100,
    parameter logic [W-1:0] RST_CS = 16'hF000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [W-1:0]      tgt_off_i,
    input  logic [W-1:0]      tgt_seg_i,
    input  logic [TYPE_W-1:0] int_type_i,
    input  logic              of_i,
    input  logic [W-1:0]      flags_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [W-1:0]      mem_addr_o,
    output logic [W-1:0]      mem_wdata_o,
    input  logic [W-1:0]      mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              clr_if_o,
    output logic              flags_load_o,
    output logic [W-1:0]      flags_o,
    output logic [W-1:0]      sp_o,
    output logic [W-1:0]      ip_o,
    output logic [W-1:0]      cs_o
);

    st_e  state;
    op_e  op_q;
    op_e  op_in;
    logic take;

    assign op_in = op_e'(op_i);

    ctlflow_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .op_i         (op_in),
        .of_i         (of_i),
        .ack_i        (mem_ack_i),
        .state_o      (state),
        .op_q_o       (op_q),
        .take_o       (take),
        .req_o        (mem_req_o),
        .we_o         (mem_we_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .clr_if_o     (clr_if_o),
        .flags_load_o (flags_load_o)
    );

    ctlflow_dpath #(
        .W      (W),
        .TYPE_W (TYPE_W),
        .RST_SP (RST_SP),
        .RST_IP (RST_IP),
        .RST_CS (RST_CS)
    ) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state),
        .op_q_i     (op_q),
        .op_i       (op_in),
        .take_i     (take),
        .ack_i      (mem_ack_i),
        .tgt_off_i  (tgt_off_i),
        .tgt_seg_i  (tgt_seg_i),
        .int_type_i (int_type_i),
        .flags_i    (flags_i),
        .rdata_i    (mem_rdata_i),
        .addr_o     (mem_addr_o),
        .wdata_o    (mem_wdata_o),
        .sp_o       (sp_o),
        .ip_o       (ip_o),
        .cs_o       (cs_o),
        .flags_o    (flags_o)
    );

endmodule

// File: rtl/ctlflow_sva.sv
module ctlflow_sva #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         mem_req_o,
    input logic         mem_we_o,
    input logic         mem_ack_i,
    input logic         busy_o,
    input logic         done_o,
    input logic         clr_if_o,
    input logic         flags_load_o,
    input logic [W-1:0] mem_addr_o,
    input logic [W-1:0] sp_o,
    input logic [W-1:0] ip_o,
    input logic [W-1:0] cs_o
);

    localparam logic [W-1:0] STEP = 2;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R10

    AST_REGS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ack_i |=> $stable(sp_o) && $stable(ip_o) && $stable(cs_o)); // R10

    AST_PUSH_LOWERS_SP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o && mem_ack_i |=> sp_o == $past(sp_o) - STEP); // R2

    AST_WRITE_BELOW_SP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |-> mem_addr_o == sp_o - STEP); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o && !done_o); // R11

    AST_CLRIF_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_if_o |-> done_o); // R6

    AST_FLLOAD_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        flags_load_o |-> done_o); // R9

    AST_BUSY_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o && start_i |=> busy_o); // R12

endmodule

bind ctlflow_seq ctlflow_sva #(.W(W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_ack_i    (mem_ack_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .clr_if_o     (clr_if_o),
    .flags_load_o (flags_load_o),
    .mem_addr_o   (mem_addr_o),
    .sp_o         (sp_o),
    .ip_o         (ip_o),
    .cs_o         (cs_o)
);

// File: tb/ctlflow_seq_tb_top.sv
module ctlflow_seq_tb_top;

    localparam int          W      = 16;
    localparam logic [15:0] RST_SP = 16'h0200;
    localparam logic [15:0] RST_IP = 16'h0100;
    localparam logic [15:0] RST_CS = 16'hF000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [15:0] tgt_off_i = '0, tgt_seg_i = '0, flags_i = 16'h0246;
    logic [7:0]  int_type_i = '0;
    logic        of_i = 1'b0;
    logic        mem_req_o, mem_we_o, busy_o, done_o, clr_if_o, flags_load_o;
    logic [15:0] mem_addr_o, mem_wdata_o, flags_o, sp_o, ip_o, cs_o;
    logic [15:0] rdata = '0;
    logic        ack = 1'b0;

    always #5 clk = ~clk;

    ctlflow_seq #(.RST_SP(RST_SP), .RST_IP(RST_IP), .RST_CS(RST_CS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .tgt_off_i(tgt_off_i), .tgt_seg_i(tgt_seg_i), .int_type_i(int_type_i),
        .of_i(of_i), .flags_i(flags_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(rdata),
        .mem_ack_i(ack), .busy_o(busy_o), .done_o(done_o), .clr_if_o(clr_if_o),
        .flags_load_o(flags_load_o), .flags_o(flags_o), .sp_o(sp_o), .ip_o(ip_o), .cs_o(cs_o)
    );

    typedef struct {
        bit          we;
        logic [15:0] addr;
        logic [15:0] data;
        string       rq;
    } acc_t;

    acc_t        exp_q[$];
    logic [15:0] mem [int];
    int          checks = 0, fails = 0;
    int          lat = 0, wcnt = 0;
    longint      cyc = 0, last_ack = 0;
    logic [15:0] m_sp = RST_SP, m_ip = RST_IP, m_cs = RST_CS;

    always @(posedge clk) cyc++;

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rd(input logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 16'hDEAD;
    endfunction

    task automatic expect_acc(input bit we, input logic [15:0] a, input logic [15:0] d, input string rq);
        acc_t e;
        e.we = we; e.addr = a; e.data = d; e.rq = rq;
        exp_q.push_back(e);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // monitor and memory model: compares every request cycle with the scoreboard head
    always @(negedge clk) begin
        if (ack) begin
            ack = 1'b0;
        end else if (mem_req_o) begin
            if (exp_q.size() == 0) begin
                chk("R10", "unexpected access addr", {16'h0, mem_addr_o}, 32'hFFFF_FFFF);
                ack = 1'b1;
            end else begin
                chk(exp_q[0].rq, "access direction", {31'h0, mem_we_o}, {31'h0, exp_q[0].we});
                chk(exp_q[0].rq, "access address", {16'h0, mem_addr_o}, {16'h0, exp_q[0].addr});
                if (exp_q[0].we)
                    chk(exp_q[0].rq, "write data", {16'h0, mem_wdata_o}, {16'h0, exp_q[0].data});
                if (wcnt >= lat) begin
                    ack  = 1'b1;
                    wcnt = 0;
                    if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
                    else          rdata = rd(mem_addr_o);
                    last_ack = cyc;
                    void'(exp_q.pop_front());
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic run(input logic [2:0] op, input logic [15:0] off, input logic [15:0] seg,
                       input logic [7:0] ty, input logic ov, input int l, input bit poke,
                       input string rq);
        logic [15:0] nsp = m_sp, nip = m_ip, ncs = m_cs, vb, fl_exp = '0;
        bit          intr = 0, fl_ld = 0, has_mem = 1;
        longint      start_c;
        lat = l;
        case (op)
            3'd0: begin
                expect_acc(1, m_sp - 16'd2, m_ip, rq);
                nsp = m_sp - 16'd2; nip = off;
            end
            3'd1: begin
                expect_acc(1, m_sp - 16'd2, m_cs, rq);
                expect_acc(1, m_sp - 16'd4, m_ip, rq);
                nsp = m_sp - 16'd4; nip = off; ncs = seg;
            end
            3'd2: begin
                expect_acc(0, m_sp, 16'h0, rq);
                nip = rd(m_sp); nsp = m_sp + 16'd2;
            end
            3'd3: begin
                expect_acc(0, m_sp, 16'h0, rq);
                expect_acc(0, m_sp + 16'd2, 16'h0, rq);
                nip = rd(m_sp); ncs = rd(m_sp + 16'd2); nsp = m_sp + 16'd4;
            end
            3'd4, 3'd5: begin
                if (op == 3'd4 || ov) begin
                    intr = 1;
                    vb = (op == 3'd4) ? {6'b0, ty, 2'b00} : 16'h0010;
                    expect_acc(1, m_sp - 16'd2, flags_i, rq);
                    expect_acc(1, m_sp - 16'd4, m_cs, rq);
                    expect_acc(1, m_sp - 16'd6, m_ip, rq);
                    expect_acc(0, vb, 16'h0, rq);
                    expect_acc(0, vb + 16'd2, 16'h0, rq);
                    nsp = m_sp - 16'd6; nip = rd(vb); ncs = rd(vb + 16'd2);
                end else begin
                    has_mem = 0;
                end
            end
            3'd6: begin
                expect_acc(0, m_sp, 16'h0, rq);
                expect_acc(0, m_sp + 16'd2, 16'h0, rq);
                expect_acc(0, m_sp + 16'd4, 16'h0, rq);
                nip = rd(m_sp); ncs = rd(m_sp + 16'd2); fl_exp = rd(m_sp + 16'd4);
                nsp = m_sp + 16'd6; fl_ld = 1;
            end
            default: has_mem = 0;
        endcase

        @(negedge clk);
        op_i = op; tgt_off_i = off; tgt_seg_i = seg; int_type_i = ty; of_i = ov;
        start_i = 1'b1;
        start_c = cyc;
        @(negedge clk);
        start_i = 1'b0;
        chk("R11", "busy after start", {31'h0, busy_o}, 32'h1);
        for (int k = 0; k < 80 && !done_o; k++) begin
            if (poke && k == 1) begin start_i = 1'b1; op_i = 3'd2; end  // R12 injected start
            if (poke && k == 2) start_i = 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk("R11", "done seen", {31'h0, done_o}, 32'h1);
        if (has_mem) chk("R11", "done one cycle after last ack", cyc[31:0], last_ack[31:0] + 32'd1);
        else         chk("R8", "done one cycle after start", cyc[31:0], start_c[31:0] + 32'd1);
        chk(rq, "pending accesses", exp_q.size(), 32'd0);
        chk(rq, "sp", {16'h0, sp_o}, {16'h0, nsp});
        chk(rq, "ip", {16'h0, ip_o}, {16'h0, nip});
        chk(rq, "cs", {16'h0, cs_o}, {16'h0, ncs});
        chk(intr ? "R6" : "R8", "clr_if pulse", {31'h0, clr_if_o}, {31'h0, intr});
        chk("R9", "flags_load pulse", {31'h0, flags_load_o}, {31'h0, fl_ld});
        if (fl_ld) chk("R9", "popped flags", {16'h0, flags_o}, {16'h0, fl_exp});
        @(negedge clk);
        chk("R11", "done single cycle", {31'h0, done_o}, 32'h0);
        chk("R11", "idle after done", {31'h0, busy_o}, 32'h0);
        m_sp = nsp; m_ip = nip; m_cs = ncs;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R11 watchdog expired: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        mem[32'h000C] = 16'h5555;  mem[32'h000E] = 16'h6666;
        mem[32'h0010] = 16'h7777;  mem[32'h0012] = 16'h8888;
        mem[32'h03FC] = 16'h9AB0;  mem[32'h03FE] = 16'hC0DE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset sp", {16'h0, sp_o}, {16'h0, RST_SP});
        chk("R1", "reset ip", {16'h0, ip_o}, {16'h0, RST_IP});
        chk("R1", "reset cs", {16'h0, cs_o}, {16'h0, RST_CS});
        chk("R1", "reset idle", {29'h0, mem_req_o, done_o, busy_o}, 32'h0);

        run(3'd0, 16'h1234, 16'h0000, 8'h00, 1'b0, 0, 0, "R2");   // near call
        run(3'd1, 16'h2000, 16'h3000, 8'h00, 1'b0, 1, 1, "R3");   // far call, R12 poke
        run(3'd3, 16'h0000, 16'h0000, 8'h00, 1'b0, 2, 0, "R5");   // far return
        run(3'd2, 16'h0000, 16'h0000, 8'h00, 1'b0, 1, 0, "R4");   // near return
        run(3'd4, 16'h0000, 16'h0000, 8'h03, 1'b0, 2, 0, "R6");   // software interrupt type 3
        run(3'd6, 16'h0000, 16'h0000, 8'h00, 1'b0, 0, 0, "R9");   // interrupt return
        run(3'd5, 16'h0000, 16'h0000, 8'h03, 1'b0, 0, 0, "R8");   // overflow clear
        flags_i = 16'h0A83;
        run(3'd5, 16'h0000, 16'h0000, 8'h55, 1'b1, 1, 0, "R7");   // overflow set
        run(3'd6, 16'h0000, 16'h0000, 8'h00, 1'b0, 2, 0, "R9");
        flags_i = 16'h0202;
        run(3'd4, 16'h0000, 16'h0000, 8'hFF, 1'b0, 0, 0, "R6");   // top vector type
        run(3'd6, 16'h0000, 16'h0000, 8'h00, 1'b0, 1, 0, "R9");
        run(3'd7, 16'h4444, 16'h5555, 8'h00, 1'b0, 0, 0, "R8");   // spare code
        chk("R10", "no stray access", exp_q.size(), 32'd0);

        summary();
        $finish;
    end

endmodule